// File: doc/BRIEF.md
# Multi-Channel Compare Timer

This block is a register-mapped timer with several independent 32-bit up-counters. Each channel has its own control, tick-selection, count and compare registers. It can stop after one compare hit, reload and run periodically, or run freely and ignore the compare value. Each channel counts tick pulses from one of two tick-enable inputs, a fast one and a slow one. It can optionally count only every second tick. A shared pair of registers holds the per-channel interrupt enables and the pending flags. Pending flags are cleared by writing ones.

Software reaches the block over a plain single-cycle bus. Writes take effect at the clock edge, and read data is presented combinationally in the same cycle. Typical use puts one channel in free-run as a time base that software reads. Another channel runs in one-shot or repeat mode and drives the combined interrupt line. Channels are numbered from 1. Channel n occupies a 16-byte window at byte offset 0x10·n, so the window at offset zero holds the global interrupt registers.

Top module: `ctmr_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Register map. The interrupt-enable register is at 0x00 and the pending/acknowledge register is at 0x08; channel n uses bit n-1 in both. Channel n has control at 0x10·n, tick select at 0x10·n+4, counter at 0x10·n+8 and compare at 0x10·n+0xC. Every other address reads zero and ignores writes. This covers 0x04, 0x0C, addresses with nonzero low two bits, windows beyond the last channel, and enable or pending bits above the channel count.
- R3: In the control register, bit 0 is run-enable and bit 1 is clear. Bits [5:4] set the mode: 0 is one-shot, 1 is repeat, 3 is free-run, and 2 behaves as one-shot. Clear zeroes the counter and the divider phase, and it always reads back 0. A tick that arrives in the same cycle as a write to a channel's control or tick-select register is not counted.
- R4: Tick-select bit 4 chooses the source: 0 selects `fast_tick` and 1 selects `slow_tick`. An enabled channel advances by one on each clock in which its selected tick is high.
- R5: Tick-select bit 0 set to 1 halves the rate, so only every second selected tick advances the counter. The first tick after a clear or a tick-select write is skipped. The other bits of the tick-select register read zero.
- R6: In one-shot mode, a tick that would bring the counter to the compare value stores that value, sets the channel's pending bit and clears run-enable, so the control register reads bit 0 as 0.
- R7: In repeat mode the same tick sets pending and reloads the counter to 0, and counting continues. The period is the compare value in counted ticks.
- R8: In free-run mode the counter ignores the compare value, never sets pending, and wraps from 0xFFFFFFFF to 0.
- R9: Writing 1 to a bit of the register at 0x08 clears that pending bit, and writing 0 leaves it unchanged. When a compare hit and an acknowledge of the same bit fall in one cycle, the bit stays set.
- R10: `irq` is the OR over all channels of pending AND enable. The enable register masks only the output and never alters the pending bits.
- R11: Writing run-enable to 0 freezes the counter at its value. Writing it back to 1 without clear resumes counting from that value.
- R12: The compare register holds a full 32-bit value that can be written and read. The counter register is read-only, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the cycle of the read, zero otherwise |
| fast_tick | input | 1 | Fast tick enable, already synchronous to clk |
| slow_tick | input | 1 | Slow tick enable, already synchronous to clk |
| irq | output | 1 | Combined interrupt |

## Verification
Two collisions matter here. The first is a compare hit that sets a pending bit in the same cycle that software writes a one to acknowledge it. The bench's model predicts the cycle in which a repeat-mode channel will hit, and the bench issues the acknowledge write in exactly that cycle. It then expects the pending bit to read back 1 and `irq` to stay high. The second is a tick that arrives together with a control write. Ticks run every cycle while control writes start, stop and resume channels, and each counter read is compared with the model, which discards the tick in any cycle that carries a control write.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  typedef enum logic [1:0] {
    MODE_ONCE = 2'd0,
    MODE_LOOP = 2'd1,
    MODE_RSVD = 2'd2,
    MODE_FREE = 2'd3
  } ctmr_mode_e;

  // word index inside a channel window (addr[3:2])
  localparam logic [1:0] WORD_CTRL = 2'd0;
  localparam logic [1:0] WORD_TSEL = 2'd1;
  localparam logic [1:0] WORD_CNT  = 2'd2;
  localparam logic [1:0] WORD_CMP  = 2'd3;

  // word index inside the global window
  localparam logic [1:0] WORD_IEN  = 2'd0;
  localparam logic [1:0] WORD_PEND = 2'd2;

  // control fields
  localparam int CTL_RUN_BIT  = 0;
  localparam int CTL_CLR_BIT  = 1;
  localparam int CTL_MODE_LSB = 4;

  // tick-select fields
  localparam int TS_DIV_BIT = 0;
  localparam int TS_SRC_BIT = 4;

endpackage

// File: rtl/ctmr_tick_gen.sv
module ctmr_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_tick,
  input  logic slow_tick,
  input  logic src_slow,
  input  logic div2,
  input  logic run,
  input  logic phase_rst,
  output logic step
);

  logic sel_tick;
  logic phase_q;
  logic phase_d;

  assign sel_tick = src_slow ? slow_tick : fast_tick;
  assign step     = run && sel_tick && (!div2 || phase_q);

  always_comb begin
    phase_d = phase_q;
    if (phase_rst) begin
      phase_d = 1'b0;
    end else if (run && sel_tick && div2) begin
      phase_d = ~phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
    end
  end

  // R5
  div_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div2 && step) |=> !phase_q);

endmodule

// File: rtl/ctmr_channel.sv
module ctmr_channel
  import ctmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_tick,
  input  logic             slow_tick,
  input  logic             wr_ctrl,
  input  logic             wr_tsel,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] ctrl_rd,
  output logic [CNT_W-1:0] tsel_rd,
  output logic [CNT_W-1:0] cnt_rd,
  output logic [CNT_W-1:0] cmp_rd,
  output logic             hit_o
);

  logic             run_q, run_d;
  ctmr_mode_e       mode_q, mode_d;
  logic             src_q, div_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             run_now;
  logic             clr_req;
  logic             step;
  logic             hit;

  assign run_now = run_q && !wr_ctrl && !wr_tsel;
  assign clr_req = wr_ctrl && wdata[CTL_CLR_BIT];

  ctmr_tick_gen u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_tick (fast_tick),
    .slow_tick (slow_tick),
    .src_slow  (src_q),
    .div2      (div_q),
    .run       (run_now),
    .phase_rst (clr_req || wr_tsel),
    .step      (step)
  );

  assign cnt_inc = cnt_q + 1'b1;
  assign hit     = step && (mode_q != MODE_FREE) && (cnt_inc == cmp_q);

  always_comb begin
    run_d  = run_q;
    mode_d = mode_q;
    cnt_d  = cnt_q;
    if (wr_ctrl) begin
      run_d  = wdata[CTL_RUN_BIT];
      mode_d = ctmr_mode_e'(wdata[CTL_MODE_LSB +: 2]);
      if (wdata[CTL_CLR_BIT]) begin
        cnt_d = '0;
      end
    end else if (step) begin
      if (hit) begin
        if (mode_q == MODE_LOOP) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_inc;
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= MODE_ONCE;
      cnt_q  <= '0;
    end else begin
      run_q  <= run_d;
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      div_q <= 1'b0;
    end else if (wr_tsel) begin
      src_q <= wdata[TS_SRC_BIT];
      div_q <= wdata[TS_DIV_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (wr_cmp) begin
      cmp_q <= wdata;
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTL_RUN_BIT]       = run_q;
    ctrl_rd[CTL_MODE_LSB +: 2] = mode_q;
    tsel_rd = '0;
    tsel_rd[TS_SRC_BIT] = src_q;
    tsel_rd[TS_DIV_BIT] = div_q;
  end

  assign cnt_rd = cnt_q;
  assign cmp_rd = cmp_q;
  assign hit_o  = hit;

  // R6
  once_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q != MODE_LOOP) |=> (!run_q && cnt_q == $past(cmp_q)));

  // R7
  loop_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q == MODE_LOOP) |=> (cnt_q == '0 && run_q));

  // R8
  free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode_q == MODE_FREE && cnt_q == {CNT_W{1'b1}}) |=> (cnt_q == '0));

  // R11
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_ctrl) |=> $stable(cnt_q));

endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
  import ctmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              fast_tick,
  input  logic              slow_tick,
  output logic              irq
);

  localparam int RG_W = ADDR_W - 4;

  logic [RG_W-1:0]   region;
  logic [1:0]        word;
  logic              aligned;
  logic              wr_go;
  logic              rd_go;
  logic              ien_wr;
  logic              ack_wr;
  logic [NUM_CH-1:0] ien_q;
  logic [NUM_CH-1:0] pend_q, pend_d;
  logic [NUM_CH-1:0] ack_mask;
  logic [NUM_CH-1:0] hit_vec;
  logic [DATA_W-1:0] ch_word [NUM_CH];

  assign region  = bus_addr[ADDR_W-1:4];
  assign word    = bus_addr[3:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_go   = bus_sel && bus_wr && aligned;
  assign rd_go   = bus_sel && !bus_wr && aligned;
  assign ien_wr  = wr_go && (region == '0) && (word == WORD_IEN);
  assign ack_wr  = wr_go && (region == '0) && (word == WORD_PEND);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic              win;
    logic [DATA_W-1:0] ctrl_rd, tsel_rd, cnt_rd, cmp_rd;

    assign win = (region == RG_W'(i + 1));

    ctmr_channel #(.CNT_W(DATA_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .fast_tick (fast_tick),
      .slow_tick (slow_tick),
      .wr_ctrl   (wr_go && win && (word == WORD_CTRL)),
      .wr_tsel   (wr_go && win && (word == WORD_TSEL)),
      .wr_cmp    (wr_go && win && (word == WORD_CMP)),
      .wdata     (bus_wdata),
      .ctrl_rd   (ctrl_rd),
      .tsel_rd   (tsel_rd),
      .cnt_rd    (cnt_rd),
      .cmp_rd    (cmp_rd),
      .hit_o     (hit_vec[i])
    );

    always_comb begin
      case (word)
        WORD_CTRL: ch_word[i] = ctrl_rd;
        WORD_TSEL: ch_word[i] = tsel_rd;
        WORD_CNT:  ch_word[i] = cnt_rd;
        default:   ch_word[i] = cmp_rd;
      endcase
    end

    // R9
    pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> $past(hit_vec[i]));

    // R9
    ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && bus_wdata[i] && !hit_vec[i]) |=> !pend_q[i]);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[i] |=> pend_q[i]);
  end

  assign ack_mask = ack_wr ? bus_wdata[NUM_CH-1:0] : '0;

  always_comb begin
    pend_d = (pend_q & ~ack_mask) | hit_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
    end else if (ien_wr) begin
      ien_q <= bus_wdata[NUM_CH-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_go) begin
      if (region == '0) begin
        if (word == WORD_IEN) begin
          bus_rdata[NUM_CH-1:0] = ien_q;
        end else if (word == WORD_PEND) begin
          bus_rdata[NUM_CH-1:0] = pend_q;
        end
      end else begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (region == RG_W'(i + 1)) begin
            bus_rdata = ch_word[i];
          end
        end
      end
    end
  end

  assign irq = |(pend_q & ien_q);

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_wr && bus_wdata[NUM_CH-1:0] == '0) |=> !irq);

endmodule

// File: tb/ctmr_top_tb_top.sv
module ctmr_top_tb_top;

  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        fast_tick, slow_tick;
  logic        irq;

  always #4 clk = ~clk;

  ctmr_top #(.NUM_CH(NCH), .ADDR_W(8), .DATA_W(32)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .fast_tick (fast_tick),
    .slow_tick (slow_tick),
    .irq       (irq)
  );

  // behavioural reference state
  bit          m_en   [NCH];
  bit [1:0]    m_mode [NCH];
  bit          m_src  [NCH];
  bit          m_div  [NCH];
  bit          m_ph   [NCH];
  bit [31:0]   m_cnt  [NCH];
  bit [31:0]   m_cmp  [NCH];
  bit [NCH-1:0] m_ie;
  bit [NCH-1:0] m_pend;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit fast_on = 1'b1;

  function automatic bit [31:0] model_read(input bit [7:0] a);
    int rg;
    int idx;
    if (a[1:0] != 2'b00) return 32'h0;
    rg = int'(a[7:4]);
    if (rg == 0) begin
      if (a[3:2] == 2'd0) return 32'(m_ie);
      if (a[3:2] == 2'd2) return 32'(m_pend);
      return 32'h0;
    end
    if (rg > NCH) return 32'h0;
    idx = rg - 1;
    case (a[3:2])
      2'd0:    return {26'b0, m_mode[idx], 2'b00, 1'b0, m_en[idx]};
      2'd1:    return {27'b0, m_src[idx], 3'b000, m_div[idx]};
      2'd2:    return m_cnt[idx];
      default: return m_cmp[idx];
    endcase
  endfunction

  task automatic model_step();
    bit [NCH-1:0] hits;
    bit [NCH-1:0] ack;
    bit           wgo;
    hits = '0;
    wgo  = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00);
    for (int i = 0; i < NCH; i++) begin
      int  base;
      bit  tk;
      bit [31:0] nxt;
      base = 16 * (i + 1);
      tk   = m_src[i] ? slow_tick : fast_tick;
      if (wgo && int'(bus_addr) == base) begin
        m_en[i]   = bus_wdata[0];
        m_mode[i] = bus_wdata[5:4];
        if (bus_wdata[1]) begin
          m_cnt[i] = 0;
          m_ph[i]  = 0;
        end
      end else if (wgo && int'(bus_addr) == base + 4) begin
        m_src[i] = bus_wdata[4];
        m_div[i] = bus_wdata[0];
        m_ph[i]  = 0;
      end else if (m_en[i] && tk) begin
        if (m_div[i] && !m_ph[i]) begin
          m_ph[i] = 1;
        end else begin
          m_ph[i] = 0;
          nxt = m_cnt[i] + 1;
          if (m_mode[i] != 2'd3 && nxt == m_cmp[i]) begin
            hits[i] = 1'b1;
            if (m_mode[i] == 2'd1) m_cnt[i] = 0;
            else begin
              m_cnt[i] = nxt;
              m_en[i]  = 0;
            end
          end else begin
            m_cnt[i] = nxt;
          end
        end
      end
      if (wgo && int'(bus_addr) == base + 12) m_cmp[i] = bus_wdata;
    end
    ack = (wgo && bus_addr == 8'h08) ? bus_wdata[NCH-1:0] : '0;
    m_pend = (m_pend & ~ack) | hits;
    if (wgo && bus_addr == 8'h00) m_ie = bus_wdata[NCH-1:0];
  endtask

  task automatic check(input bit [31:0] act, input bit [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input bit do_rd, input string tag, input bit lit, input bit [31:0] lexp);
    fast_tick = fast_on;
    slow_tick = (cyc % 3 == 0);
    #1;
    check(32'(irq), 32'(|(m_pend & m_ie)), "R10 irq vs model");
    if (do_rd) begin
      check(bus_rdata, model_read(bus_addr), tag);
      if (lit) check(bus_rdata, lexp, tag);
    end
    @(posedge clk);
    model_step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    step(0, "", 0, 0);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input bit [7:0] a, input string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    step(1, tag, 0, 0);
    bus_sel = 0;
  endtask

  task automatic rdl(input bit [7:0] a, input bit [31:0] e, input string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    step(1, tag, 1, e);
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, "", 0, 0);
  endtask

  function automatic bit ch2_hits_next();
    return m_en[1] && m_mode[1] != 2'd3 && (m_cnt[1] + 32'd1) == m_cmp[1];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit acked;
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    fast_tick = 0; slow_tick = 0;
    repeat (3) @(negedge clk);
    #1 check(32'(irq), 0, "R1 irq in reset");
    @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rdl(8'h00, 0, "R1 ien reset");
    rdl(8'h08, 0, "R1 pend reset");
    rdl(8'h10, 0, "R1 ctrl reset");
    rdl(8'h18, 0, "R1 cnt reset");
    rdl(8'h2C, 0, "R1 cmp reset");

    // R12 compare storage, counter read-only
    wr(8'h1C, 32'hDEADBEEF);
    rdl(8'h1C, 32'hDEADBEEF, "R12 cmp readback");
    wr(8'h18, 32'h55);
    rdl(8'h18, 0, "R12 cnt write ignored");

    // R2 unused space
    wr(8'h04, 32'hFFFFFFFF);
    rdl(8'h04, 0, "R2 hole 0x04");
    wr(8'h30, 32'hFFFFFFFF);
    rdl(8'h30, 0, "R2 beyond last channel");
    rdl(8'h1D, 0, "R2 misaligned read");
    wr(8'h00, 32'hFFFFFFFF);
    rdl(8'h00, 32'h3, "R2 ien width");

    // R3/R6 one-shot on ch1, fast tick
    wr(8'h14, 32'h0);
    wr(8'h1C, 32'd5);
    wr(8'h10, 32'h03);
    rdl(8'h10, 32'h01, "R3 clear reads 0");
    idle(6);
    rdl(8'h18, 32'd5, "R6 stops at compare");
    rdl(8'h10, 32'h00, "R6 run cleared");
    rdl(8'h08, 32'h1, "R6 pending set");
    check(32'(irq), 1, "R10 irq high");
    wr(8'h00, 32'h0);
    #1 check(32'(irq), 0, "R10 irq masked");
    rdl(8'h08, 32'h1, "R10 mask keeps pending");
    wr(8'h00, 32'h3);

    // R9 acknowledge
    wr(8'h08, 32'h0);
    rdl(8'h08, 32'h1, "R9 zero write no effect");
    wr(8'h08, 32'h1);
    rdl(8'h08, 32'h0, "R9 ack clears");

    // R8 free-run past compare, R11 stop/resume
    wr(8'h10, 32'h33);
    idle(10);
    rdl(8'h18, 32'd10, "R8 free-run count");
    rdl(8'h08, 32'h0, "R8 no pending");
    wr(8'h10, 32'h30);
    idle(5);
    rdl(8'h18, 32'd12, "R11 held when stopped");
    wr(8'h10, 32'h31);
    idle(3);
    rdl(8'h18, 32'd15, "R11 resumed without clear");

    // R4/R5/R7 ch2 on slow tick, divide by two, repeat
    wr(8'h24, 32'h11);
    wr(8'h2C, 32'd2);
    wr(8'h20, 32'h13);
    rdl(8'h24, 32'h11, "R5 tick select readback");
    for (int k = 0; k < 30; k++) rd(8'h28, "R4 R5 R7 counter vs model");
    rd(8'h08, "R7 pending vs model");
    check(32'(m_pend[1]), 1, "R7 model saw repeat hit");
    wr(8'h08, 32'h3);

    // R9 hit and acknowledge in the same cycle
    wr(8'h24, 32'h0);
    wr(8'h2C, 32'd3);
    wr(8'h20, 32'h13);
    acked = 0;
    for (int k = 0; k < 8; k++) begin
      if (!acked && ch2_hits_next()) begin
        wr(8'h08, 32'h2);
        acked = 1;
      end else begin
        idle(1);
      end
    end
    check(32'(acked), 1, "R9 collision reached");
    rdl(8'h08, 32'h2, "R9 set wins over ack");
    wr(8'h20, 32'h10);
    wr(8'h10, 32'h30);
    wr(8'h08, 32'h3);
    rdl(8'h08, 32'h0, "R9 final ack");
    #1 check(32'(irq), 0, "R10 irq low at end");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule